// File: doc/BRIEF.md
# RTC Square-Wave and Alarm Interrupt Output Controller

This block keeps the control byte of a real-time clock and drives one shared open-drain style output pin. The pin carries either a square wave at one of four rates taken from the oscillator, or an active-low alarm interrupt. Timekeeping logic reports alarm matches as one-cycle pulses. The block latches them in a sticky alarm flag, and software clears the flag through a small register port. All logic runs on one system clock. The oscillator arrives as `osc_tick`, a one-cycle pulse at every edge of the 32.768 kHz oscillator, so 65 536 ticks make one second.

Power-fail detection is reduced to the `vcc_ok` input. While main supply is valid the oscillator divider always runs. On backup supply the divider can be frozen by the oscillator-stop bit. The pin is released unless the backup output enable bit allows it to keep working.

Top module: `rtc_sqw_ctrl`

## Requirements
- R1: After reset the control byte reads 0x18 (rate code 11, every other field 0) and the status byte reads 0x00. With `vcc_ok`=1 and no ticks yet, the pin is driven (`pin_oe`=1) low (`pin_out`=0).
- R2: A write to address 0x8D loads the control byte and a read of address 0x0D returns it. The control byte fields are: bit 7 oscillator stop, bit 5 backup output enable, bits 4:3 rate code, bit 2 interrupt mode, bit 0 alarm interrupt enable. Bits 6 and 1 always read 0. A write to 0x0D changes nothing, and a read of any address that is not decoded returns 0x00.
- R3: In square-wave mode with the divider running, the output after k ticks since the divider last sat at zero is (k / H) mod 2. The half period H is 32768 ticks for code 00 (1 Hz), 8 ticks for code 01 (4.096 kHz), 4 ticks for code 10 (8.192 kHz) and 1 tick for code 11 (32.768 kHz). Cycles without a tick do not advance it.
- R4: When the interrupt mode bit is 0 and the pin is allowed to drive, `pin_oe`=1 and `pin_out` carries the square wave. This holds even while the alarm flag is set.
- R5: While `vcc_ok`=0 and oscillator stop is 1, the divider is held at zero and the square wave stays low. With `vcc_ok`=1, or with oscillator stop at 0, the divider runs.
- R6: Every alarm-match pulse sets the alarm flag, whatever the mode and enable bits hold. The flag reads as bit 0 of the status byte at address 0x0F. A match in the same cycle as a clearing write leaves the flag set.
- R7: When the interrupt mode bit is 1, the pin is driven low only while the alarm flag and the alarm interrupt enable bit are both 1. Otherwise it is released (`pin_oe`=0).
- R8: The alarm flag stays set until a write to address 0x8F with bit 0 equal to 0 clears it. A write there with bit 0 equal to 1 has no effect.
- R9: While `vcc_ok`=0 and backup output enable is 0, the pin is released in both modes. With backup output enable at 1, the pin behaves as R4 and R7 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| osc_tick | input | 1 | One pulse per oscillator edge (two per 32.768 kHz cycle) |
| vcc_ok | input | 1 | Main supply valid; 0 means running on backup |
| alarm_hit | input | 1 | One-cycle alarm match pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| pin_oe | output | 1 | Pin output enable; 0 is high impedance |
| pin_out | output | 1 | Pin data while enabled |

## Verification
An alarm-match pulse can arrive in the same clock cycle as a software write that clears the flag. The bench provokes this by raising `alarm_hit` and a clearing status write together. It then reads the status byte and expects the flag still set, because a new match must not be lost. A second overlap is a supply drop while the pin is asserting an interrupt. The bench judges that case by `pin_oe` with the backup output enable at 0 and then at 1.

// File: rtl/rtc_sqw_pkg.sv
package rtc_sqw_pkg;

   typedef enum logic [1:0] {
      RATE_1HZ  = 2'b00,
      RATE_4K   = 2'b01,
      RATE_8K   = 2'b10,
      RATE_32K  = 2'b11
   } rate_e;

   typedef struct packed {
      logic  osc_stop;
      logic  bkp_en;
      rate_e rate;
      logic  int_mode;
      logic  alm_ie;
   } ctrl_t;

   localparam ctrl_t CTRL_POR = '{osc_stop: 1'b0, bkp_en: 1'b0, rate: RATE_32K,
                                  int_mode: 1'b0, alm_ie: 1'b0};

   // byte image seen by software; positions are decoded by firmware
   function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
      return {c.osc_stop, 1'b0, c.bkp_en, c.rate, c.int_mode, 1'b0, c.alm_ie};
   endfunction

   function automatic ctrl_t byte_to_ctrl(logic [7:0] b);
      ctrl_t c;
      c.osc_stop = b[7];
      c.bkp_en   = b[5];
      c.rate     = rate_e'(b[4:3]);
      c.int_mode = b[2];
      c.alm_ie   = b[0];
      return c;
   endfunction

endpackage

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
   import rtc_sqw_pkg::*;
#(
   parameter logic [7:0] CTRL_RD = 8'h0D,
   parameter logic [7:0] CTRL_WR = 8'h8D,
   parameter logic [7:0] STAT_RD = 8'h0F,
   parameter logic [7:0] STAT_WR = 8'h8F
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [7:0]  bus_addr,
   input  logic [7:0]  bus_wdata,
   input  logic        alarm_hit,
   output ctrl_t       ctrl,
   output logic        alarm_flag,
   output logic [7:0]  bus_rdata
);

   localparam logic [7:0] WR_BIT = 8'h80;

   if (CTRL_WR != (CTRL_RD | WR_BIT)) begin : g_bad_ctrl_addr
      $error("control write address must be read address with bit 7 set");
   end
   if (STAT_WR != (STAT_RD | WR_BIT)) begin : g_bad_stat_addr
      $error("status write address must be read address with bit 7 set");
   end
   if (CTRL_RD == STAT_RD) begin : g_addr_clash
      $error("control and status addresses must differ");
   end

   logic ctrl_we;
   logic flag_clr;

   assign ctrl_we  = bus_wr && (bus_addr == CTRL_WR);
   assign flag_clr = bus_wr && (bus_addr == STAT_WR) && !bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl <= CTRL_POR;
      else if (ctrl_we) ctrl <= byte_to_ctrl(bus_wdata);
   end

   // a fresh match outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         alarm_flag <= 1'b0;
      else if (alarm_hit) alarm_flag <= 1'b1;
      else if (flag_clr)  alarm_flag <= 1'b0;
   end

   always_comb begin
      case (bus_addr)
         CTRL_RD: bus_rdata = ctrl_to_byte(ctrl);
         STAT_RD: bus_rdata = {7'd0, alarm_flag};
         default: bus_rdata = 8'h00;
      endcase
   end

   assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |=> alarm_flag);

   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && !(bus_wr && bus_addr == STAT_WR && !bus_wdata[0])) |=> alarm_flag);

   assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == CTRL_WR) |=> (ctrl_to_byte(ctrl) == ($past(bus_wdata) & 8'hBD)));

endmodule

// File: rtl/rtc_rate_div.sv
module rtc_rate_div
   import rtc_sqw_pkg::*;
#(
   parameter int DIV_BITS = 16,
   parameter int TAP_8K   = 2,
   parameter int TAP_4K   = 3
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run,
   input  logic  tick,
   input  rate_e rate,
   output logic  sq
);

   localparam int TAP_32K = 0;
   localparam int TAP_1HZ = DIV_BITS - 1;
   localparam int NRATES  = 4;

   if (!(TAP_32K < TAP_8K && TAP_8K < TAP_4K && TAP_4K < TAP_1HZ)) begin : g_bad_taps
      $error("divider taps must rise strictly from fastest to slowest rate");
   end

   logic [DIV_BITS-1:0] cnt;
   logic [NRATES-1:0]   taps;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (tick) cnt <= cnt + 1'b1;
   end

   for (genvar r = 0; r < NRATES; r++) begin : g_tap
      localparam int POS = (r == int'(RATE_1HZ)) ? TAP_1HZ :
                           (r == int'(RATE_4K))  ? TAP_4K  :
                           (r == int'(RATE_8K))  ? TAP_8K  : TAP_32K;
      assign taps[r] = cnt[POS];
   end

   assign sq = taps[rate];

   assert_hold_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sq);

   assert_fast_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && rate == RATE_32K) |=> (rate != RATE_32K || sq != $past(sq)));

endmodule

// File: rtl/rtc_pin_mux.sv
module rtc_pin_mux (
   input  logic clk,
   input  logic rst_n,
   input  logic vcc_ok,
   input  logic bkp_en,
   input  logic int_mode,
   input  logic alm_ie,
   input  logic alarm_flag,
   input  logic sq,
   output logic pin_oe,
   output logic pin_out
);

   logic may_drive;

   assign may_drive = vcc_ok || bkp_en;

   always_comb begin
      if (int_mode) begin
         pin_oe  = may_drive && alm_ie && alarm_flag;
         pin_out = 1'b0;
      end else begin
         pin_oe  = may_drive;
         pin_out = sq;
      end
   end

   assert_int_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && !alm_ie) |-> !pin_oe);

   assert_int_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (int_mode && pin_oe) |-> !pin_out);

   assert_sq_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_mode && vcc_ok) |-> (pin_oe && pin_out == sq));

   assert_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!vcc_ok && !bkp_en) |-> !pin_oe);

endmodule

// File: rtl/rtc_sqw_ctrl.sv
module rtc_sqw_ctrl
   import rtc_sqw_pkg::*;
#(
   parameter int         DIV_BITS = 16,
   parameter int         TAP_8K   = 2,
   parameter int         TAP_4K   = 3,
   parameter logic [7:0] CTRL_RD  = 8'h0D,
   parameter logic [7:0] STAT_RD  = 8'h0F
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_tick,
   input  logic       vcc_ok,
   input  logic       alarm_hit,
   input  logic       bus_wr,
   input  logic [7:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       pin_oe,
   output logic       pin_out
);

   localparam logic [7:0] CTRL_WR = CTRL_RD | 8'h80;
   localparam logic [7:0] STAT_WR = STAT_RD | 8'h80;

   ctrl_t ctrl;
   logic  alarm_flag;
   logic  osc_run;
   logic  sq;

   rtc_ctrl_regs #(
      .CTRL_RD (CTRL_RD),
      .CTRL_WR (CTRL_WR),
      .STAT_RD (STAT_RD),
      .STAT_WR (STAT_WR)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .alarm_hit  (alarm_hit),
      .ctrl       (ctrl),
      .alarm_flag (alarm_flag),
      .bus_rdata  (bus_rdata)
   );

   // the stop bit only bites on backup supply
   assign osc_run = vcc_ok || !ctrl.osc_stop;

   rtc_rate_div #(
      .DIV_BITS (DIV_BITS),
      .TAP_8K   (TAP_8K),
      .TAP_4K   (TAP_4K)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (osc_run),
      .tick  (osc_tick),
      .rate  (ctrl.rate),
      .sq    (sq)
   );

   rtc_pin_mux u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .vcc_ok     (vcc_ok),
      .bkp_en     (ctrl.bkp_en),
      .int_mode   (ctrl.int_mode),
      .alm_ie     (ctrl.alm_ie),
      .alarm_flag (alarm_flag),
      .sq         (sq),
      .pin_oe     (pin_oe),
      .pin_out    (pin_out)
   );

   assert_stop_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!vcc_ok && ctrl.osc_stop && !ctrl.int_mode && pin_oe) |=>
         (!(!vcc_ok && ctrl.osc_stop && !ctrl.int_mode && pin_oe) || !pin_out));

endmodule

// File: tb/rtc_sqw_ctrl_bench.sv
`timescale 1ns/1ps
module rtc_sqw_ctrl_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic       vcc_ok = 1'b1;
   logic       alarm_hit = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       pin_oe;
   logic       pin_out;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   rtc_sqw_ctrl u_rtc_sqw_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_tick  (osc_tick),
      .vcc_ok    (vcc_ok),
      .alarm_hit (alarm_hit),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_oe    (pin_oe),
      .pin_out   (pin_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      cyc();
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic pulse_alarm();
      alarm_hit = 1'b1;
      cyc();
      alarm_hit = 1'b0;
   endtask

   // needs stop bit 1 and backup enable 1 in the control byte
   task automatic hold_div();
      osc_tick = 1'b1;
      vcc_ok = 1'b0;
      for (int i = 0; i < 5; i++) begin
         cyc();
         #1 chk("R5 held divider pin low", pin_out, 0);
      end
      chk("R9 driven on backup", pin_oe, 1);
      vcc_ok = 1'b1;
      osc_tick = 1'b0;
   endtask

   function automatic int half_of(input int code);
      int f;
      case (code)
         0: f = 1;
         1: f = 4096;
         2: f = 8192;
         default: f = 32768;
      endcase
      return 65536 / (2 * f);
   endfunction

   task automatic run_rate(input int code, input int n, input int stride, input string req);
      int h = half_of(code);
      int k = 0;
      for (int i = 0; i < n; i++) begin
         osc_tick = ((i % stride) == 0);
         #1 chk(req, pin_out, (k / h) % 2);
         cyc();
         if (osc_tick) k++;
      end
      osc_tick = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int lens[4];
      lens[0] = 70000; lens[1] = 128; lens[2] = 64; lens[3] = 64;
      cyc();
      cyc();
      rst_n = 1'b1;
      cyc();

      // R1 reset state
      rd(8'h0D, d); chk("R1 control reset", d, 8'h18);
      rd(8'h0F, d); chk("R1 status reset", d, 8'h00);
      chk("R1 pin enabled", pin_oe, 1);
      chk("R1 pin low", pin_out, 0);

      // R2 register access
      wr(8'h8D, 8'hFF);
      rd(8'h0D, d); chk("R2 reserved bits read zero", d, 8'hBD);
      chk("R7 no flag no pin", pin_oe, 0);
      wr(8'h0D, 8'h00);
      rd(8'h0D, d); chk("R2 write to read address ignored", d, 8'hBD);
      rd(8'h20, d); chk("R2 undecoded address", d, 8'h00);

      // R3 each rate, square-wave mode, stop and backup enable set
      for (int code = 3; code >= 0; code--) begin
         wr(8'h8D, 8'hA0 | 8'(code << 3));
         hold_div();
         run_rate(code, lens[code], 1, "R3 rate sweep");
      end
      // R3 sparse ticks at 4.096 kHz
      wr(8'h8D, 8'hA8);
      hold_div();
      run_rate(1, 150, 3, "R3 sparse ticks");

      // R5 oscillator keeps running on backup when stop bit is 0
      wr(8'h8D, 8'hB8);
      hold_div();
      wr(8'h8D, 8'h38);
      vcc_ok = 1'b0;
      run_rate(3, 16, 1, "R5 runs on backup");
      vcc_ok = 1'b1;

      // R9 square-wave mode tri-state
      wr(8'h8D, 8'h18);
      vcc_ok = 1'b0;
      #1 chk("R9 released on backup", pin_oe, 0);
      vcc_ok = 1'b1;
      #1 chk("R4 driven on main", pin_oe, 1);

      // R7/R6 interrupt enabled
      wr(8'h8D, 8'h05);
      #1 chk("R7 idle released", pin_oe, 0);
      pulse_alarm();
      #1 chk("R7 interrupt asserted", pin_oe, 1);
      chk("R7 interrupt low", pin_out, 0);
      rd(8'h0F, d); chk("R6 flag set", d, 8'h01);
      repeat (10) cyc();
      #1 chk("R8 flag persists", pin_oe, 1);
      vcc_ok = 1'b0;
      #1 chk("R9 interrupt released on backup", pin_oe, 0);
      wr(8'h8D, 8'h25);
      #1 chk("R9 interrupt kept on backup", pin_oe, 1);
      vcc_ok = 1'b1;
      wr(8'h8F, 8'h01);
      rd(8'h0F, d); chk("R8 write one keeps flag", d, 8'h01);
      wr(8'h8F, 8'hFE);
      rd(8'h0F, d); chk("R8 clear", d, 8'h00);
      #1 chk("R8 pin released after clear", pin_oe, 0);

      // R6/R7 masked interrupt
      wr(8'h8D, 8'h04);
      pulse_alarm();
      rd(8'h0F, d); chk("R6 flag set while masked", d, 8'h01);
      #1 chk("R7 masked pin released", pin_oe, 0);
      wr(8'h8D, 8'h05);
      #1 chk("R7 enable exposes pending flag", pin_oe, 1);
      wr(8'h8F, 8'h00);

      // R6/R4 alarm in square-wave mode
      wr(8'h8D, 8'h18);
      pulse_alarm();
      rd(8'h0F, d); chk("R6 flag set in square mode", d, 8'h01);
      #1 chk("R4 square mode ignores flag", pin_oe, 1);
      wr(8'h8F, 8'h00);
      rd(8'h0F, d); chk("R8 cleared", d, 8'h00);

      // R6 collision: match and clear in the same cycle
      alarm_hit = 1'b1;
      wr(8'h8F, 8'h00);
      alarm_hit = 1'b0;
      rd(8'h0F, d); chk("R6 set wins over clear", d, 8'h01);
      wr(8'h8F, 8'h00);
      rd(8'h0F, d); chk("R8 later clear", d, 8'h00);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule